// File: doc/BRIEF.md
# Legacy Interrupt Router

The block steers interrupt requests from legacy peripherals onto the eight inputs of a legacy interrupt controller. These peripherals are two serial ports, a parallel port, a floppy controller and the first disk channel. It also steers the four shared PCI interrupt pins. Every source has a four-bit selector, and the selector value is the number of the controller input that the source drives. Several sources may share one input. Their levels are ORed together.

Each controller input is conditioned on its own. A trigger bitmap selects level mode or edge mode for each input. In level mode the output follows the ORed level one clock later. In edge mode a rising edge of the ORed level sets a request, and the request stays set until the controller acknowledges that input. Software programs the selectors and the bitmap with aligned 32-bit writes to the configuration window.

Top module: `irq_router`

## Requirements
- R1: A synchronous reset sets every selector to zero and every input to edge mode. The first clock after reset shows all `irq_o` bits low.
- R2: At dword address 0x68, bits [11:8] route serial port 1 (`src_i[0]`) and bits [15:12] route serial port 2 (`src_i[1]`).
- R3: At dword address 0x68, bits [19:16] route the parallel port (`src_i[2]`) and bits [23:20] route the floppy controller (`src_i[3]`).
- R4: At dword address 0x68, bits [27:24] route disk channel 1 (`src_i[4]`). Bits [31:28] and [7:0] of that dword have no effect.
- R5: At dword address 0x6C, bits [3:0], [7:4], [11:8] and [15:12] route PCI pins A, B, C and D (`src_i[5]` to `src_i[8]`).
- R6: A selector value of 0, or of 8 or more, connects the source to no input.
- R7: At dword address 0x64, bits [31:24] form the trigger bitmap. When bit n is 1, input n runs in level mode. When bit n is 0, input n runs in edge mode.
- R8: In level mode, `irq_o[n]` equals the OR of the sources routed to n, delayed by one clock.
- R9: In edge mode, a 0-to-1 change of the ORed level sets `irq_o[n]` one clock later. The bit stays set until a cycle with `ack_i[n]` high. A rising edge in the same cycle as the acknowledge keeps the bit set.
- R10: Sources routed to the same input are ORed before conditioning. In edge mode, a second source that rises while another source already holds the line high sets no new request.
- R11: Writes to any other dword address, including 0x60 and 0x70, change no routing and no trigger setting. So do the lower 24 bits at 0x64.
- R12: A write whose address bits [1:0] are not zero is ignored.
- R13: A configuration write changes the routing from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 32 | Configuration write data |
| src_i | input | 9 | Source interrupt levels: 0 serial1, 1 serial2, 2 parallel, 3 floppy, 4 disk1, 5..8 PCI pins A..D |
| ack_i | input | 8 | Per-input acknowledge, clears an edge request |
| irq_o | output | 8 | Conditioned requests to the controller |

## Verification
The sources are pulsed one at a time under the standard routing to show the nibble-to-source mapping. Pairs of sources are then routed onto one shared input to separate the OR from per-source latching. The same pulse patterns run in edge mode and in level mode: a pulse that ends before the acknowledge shows a latched request in edge mode and a short output pulse in level mode. Writes to unused, misaligned and out-of-window addresses are followed by pulses, so a corrupted selector would appear on the outputs.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int SEL_W     = 4;
  localparam int NUM_SRC   = 9;
  localparam int DATA_W    = 32;
  localparam logic [7:0] OFS_TRIG  = 8'h64;
  localparam logic [7:0] OFS_PERIPH = 8'h68;
  localparam logic [7:0] OFS_PCI   = 8'h6C;

  typedef enum int {
    SRC_SER1 = 0, SRC_SER2 = 1, SRC_PAR = 2, SRC_FDC = 3, SRC_DSK1 = 4,
    SRC_PCIA = 5, SRC_PCIB = 6, SRC_PCIC = 7, SRC_PCID = 8
  } src_e;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_router_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int ADDR_W    = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [NUM_SRC*SEL_W-1:0]   route_o,
  output logic [NUM_LINES-1:0]       trig_o
);
  logic aligned;
  assign aligned = (addr[1:0] == 2'b00);

  always_ff @(posedge clk) begin
    if (rst) begin
      route_o <= '0;
      trig_o  <= '0;
    end else if (we && aligned) begin
      if (addr == OFS_TRIG) begin
        trig_o <= wdata[24 +: NUM_LINES];
      end
      if (addr == OFS_PERIPH) begin
        route_o[SRC_SER1*SEL_W +: SEL_W] <= wdata[11:8];
        route_o[SRC_SER2*SEL_W +: SEL_W] <= wdata[15:12];
        route_o[SRC_PAR*SEL_W  +: SEL_W] <= wdata[19:16];
        route_o[SRC_FDC*SEL_W  +: SEL_W] <= wdata[23:20];
        route_o[SRC_DSK1*SEL_W +: SEL_W] <= wdata[27:24];
      end
      if (addr == OFS_PCI) begin
        route_o[SRC_PCIA*SEL_W +: SEL_W] <= wdata[3:0];
        route_o[SRC_PCIB*SEL_W +: SEL_W] <= wdata[7:4];
        route_o[SRC_PCIC*SEL_W +: SEL_W] <= wdata[11:8];
        route_o[SRC_PCID*SEL_W +: SEL_W] <= wdata[15:12];
      end
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (trig_o == '0 && route_o == '0)); // R1
  AST_MISALIGNED_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (we && !aligned) |=> ($stable(route_o) && $stable(trig_o))); // R12
  AST_FOREIGN_ADDR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (we && addr != OFS_TRIG && addr != OFS_PERIPH && addr != OFS_PCI) |=> ($stable(route_o) && $stable(trig_o))); // R11
endmodule

// File: rtl/irq_route_mux.sv
module irq_route_mux
  import irq_router_pkg::*;
#(
  parameter int NUM_LINES = 8
) (
  input  logic [NUM_SRC*SEL_W-1:0] route_i,
  input  logic [NUM_SRC-1:0]       src_i,
  output logic [NUM_LINES-1:0]     lvl_o
);
  logic [NUM_SRC-1:0] hit [NUM_LINES];

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      if (n == 0) begin : g_none
        assign hit[n][s] = 1'b0;
      end else begin : g_dec
        assign hit[n][s] = (route_i[s*SEL_W +: SEL_W] == SEL_W'(n));
      end
    end
    assign lvl_o[n] = |(hit[n] & src_i);
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_chk
    logic [NUM_LINES-1:0] col;
    for (genvar n = 0; n < NUM_LINES; n++) begin : g_col
      assign col[n] = hit[n][s];
    end
    always_comb begin
      AST_SRC_ONE_LINE: assert ($onehot0(col)); // R6
    end
  end
endmodule

// File: rtl/irq_line_cond.sv
module irq_line_cond (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  input  logic level_mode_i,
  input  logic ack_i,
  output logic irq_o
);
  logic lvl_prev;
  logic rise;
  assign rise = lvl_i & ~lvl_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_prev <= 1'b0;
      irq_o    <= 1'b0;
    end else begin
      lvl_prev <= lvl_i;
      if (level_mode_i) irq_o <= lvl_i;
      else              irq_o <= (irq_o & ~ack_i) | rise;
    end
  end

  AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    level_mode_i |=> (irq_o == $past(lvl_i))); // R8
  AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!level_mode_i && irq_o && !ack_i) |=> irq_o); // R9
  AST_EDGE_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    (!level_mode_i && !irq_o && !(lvl_i && !lvl_prev)) |=> !irq_o); // R10
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int ADDR_W    = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [ADDR_W-1:0]     cfg_addr,
  input  logic [DATA_W-1:0]     cfg_wdata,
  input  logic [NUM_SRC-1:0]    src_i,
  input  logic [NUM_LINES-1:0]  ack_i,
  output logic [NUM_LINES-1:0]  irq_o
);
  logic [NUM_SRC*SEL_W-1:0] route;
  logic [NUM_LINES-1:0]     trig;
  logic [NUM_LINES-1:0]     lvl;

  irq_cfg_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .route_o(route), .trig_o(trig)
  );

  irq_route_mux #(.NUM_LINES(NUM_LINES)) u_mux (
    .route_i(route), .src_i(src_i), .lvl_o(lvl)
  );

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_cond
    irq_line_cond u_cond (
      .clk(clk), .rst(rst), .lvl_i(lvl[n]), .level_mode_i(trig[n]),
      .ack_i(ack_i[n]), .irq_o(irq_o[n])
    );
  end

  AST_LINE0_QUIET: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> !irq_o[0]); // R6
endmodule

// File: tb/irq_router_tb.sv
module irq_router_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [8:0]  src_i = '0;
  logic [7:0]  ack_i = '0;
  logic [7:0]  irq_o;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";

  int   m_rt [9];
  logic [7:0] m_trig, m_prev, m_out;

  irq_router u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .src_i(src_i), .ack_i(ack_i), .irq_o(irq_o)
  );

  always #5 clk = ~clk;

  // behavioural reference
  always @(posedge clk) begin
    logic [7:0] lv;
    if (rst) begin
      foreach (m_rt[i]) m_rt[i] = 0;
      m_trig = '0; m_prev = '0; m_out = '0;
    end else begin
      lv = '0;
      foreach (m_rt[i])
        if (m_rt[i] >= 1 && m_rt[i] <= 7 && src_i[i]) lv[m_rt[i]] = 1'b1;
      for (int n = 0; n < 8; n++)
        m_out[n] = m_trig[n] ? lv[n] : ((m_out[n] && !ack_i[n]) || (lv[n] && !m_prev[n]));
      m_prev = lv;
      if (cfg_we && cfg_addr[1:0] == 2'b00) begin
        if (cfg_addr == 8'h64) m_trig = cfg_wdata[31:24];
        if (cfg_addr == 8'h68) begin
          m_rt[0] = int'(cfg_wdata[11:8]);  m_rt[1] = int'(cfg_wdata[15:12]);
          m_rt[2] = int'(cfg_wdata[19:16]); m_rt[3] = int'(cfg_wdata[23:20]);
          m_rt[4] = int'(cfg_wdata[27:24]);
        end
        if (cfg_addr == 8'h6C) begin
          m_rt[5] = int'(cfg_wdata[3:0]);  m_rt[6] = int'(cfg_wdata[7:4]);
          m_rt[7] = int'(cfg_wdata[11:8]); m_rt[8] = int'(cfg_wdata[15:12]);
        end
      end
    end
  end

  // compare every cycle away from the edge
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (irq_o !== m_out) begin
        failures++;
        $display("FAIL %s: irq_o actual=%b expected=%b at %0t", cur_req, irq_o, m_out, $time);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    cyc(1);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input int s, input int len);
    src_i[s] = 1'b1; cyc(len); src_i[s] = 1'b0; cyc(2);
  endtask

  task automatic ack(input logic [7:0] m);
    ack_i = m; cyc(1); ack_i = '0; cyc(1);
  endtask

  task automatic expect_irq(input logic [7:0] e);
    checks++;
    if (irq_o !== e) begin
      failures++;
      $display("FAIL %s: directed irq_o actual=%b expected=%b", cur_req, irq_o, e);
    end
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cyc(3); rst = 1'b0; cyc(1);
    cur_req = "R1"; expect_irq(8'h00); pulse(0, 2); expect_irq(8'h00);

    cur_req = "R2"; wr(8'h68, 32'h0765_4300); wr(8'h6C, 32'h0000_1000); wr(8'h64, 32'h8200_0000);
    pulse(0, 1); expect_irq(8'h08); ack(8'h08);
    pulse(1, 3); expect_irq(8'h10); ack(8'h10);
    cur_req = "R3"; pulse(2, 1); expect_irq(8'h20); pulse(3, 1); expect_irq(8'h60); ack(8'h60);
    cur_req = "R4"; src_i[4] = 1'b1; cyc(2); expect_irq(8'h80); src_i[4] = 1'b0; cyc(2); expect_irq(8'h00);
    cur_req = "R5"; src_i[8] = 1'b1; cyc(2); expect_irq(8'h02); src_i[8] = 1'b0; cyc(1); expect_irq(8'h00);
    wr(8'h6C, 32'h0000_7654); pulse(5, 1); pulse(6, 1); pulse(7, 1); expect_irq(8'h70); ack(8'hFF);

    cur_req = "R6"; wr(8'h68, 32'h09F0_0000); pulse(0, 1); pulse(2, 1); pulse(3, 1); pulse(4, 1); expect_irq(8'h00);

    cur_req = "R7"; wr(8'h64, 32'h0000_0000); wr(8'h6C, 32'h0000_1000);
    src_i[8] = 1'b1; cyc(2); expect_irq(8'h02); src_i[8] = 1'b0; cyc(2); expect_irq(8'h02); ack(8'h02);
    cur_req = "R8"; wr(8'h64, 32'hFF00_0000); pulse(8, 1); expect_irq(8'h00);

    cur_req = "R9"; wr(8'h64, 32'h0000_0000); wr(8'h68, 32'h0000_0300);
    src_i[0] = 1'b1; cyc(1); src_i[0] = 1'b0; cyc(1); src_i[0] = 1'b1; ack_i = 8'h08; cyc(1);
    ack_i = '0; src_i[0] = 1'b0; cyc(2); expect_irq(8'h08); ack(8'h08); expect_irq(8'h00);

    cur_req = "R10"; wr(8'h68, 32'h0000_3300);
    src_i[0] = 1'b1; cyc(2); ack(8'h08); src_i[1] = 1'b1; cyc(2); expect_irq(8'h00);
    src_i[0] = 1'b0; src_i[1] = 1'b0; cyc(2);
    wr(8'h64, 32'h0800_0000); src_i[1] = 1'b1; cyc(2); expect_irq(8'h08); src_i = '0; cyc(2);

    cur_req = "R11"; wr(8'h64, 32'h0000_0000); wr(8'h70, 32'hFFFF_FFFF); wr(8'h60, 32'hFFFF_FFFF);
    wr(8'h64, 32'h00FF_FFFF); wr(8'h68, 32'hF000_33FF);
    pulse(1, 1); expect_irq(8'h08); ack(8'h08);
    cur_req = "R12"; wr(8'h69, 32'h0000_5500); wr(8'h66, 32'hFF00_0000); pulse(1, 1); expect_irq(8'h08); ack(8'h08);
    cur_req = "R13"; src_i[2] = 1'b1; wr(8'h68, 32'h0004_0000); cyc(1); expect_irq(8'h10); src_i = '0; ack(8'h10);

    cyc(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule